// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block holds the host-visible event flags of a network controller and turns them into one active-low interrupt line. The datapath sends single-cycle pulses for six events: babble (transmitter on the wire too long), collision-check error, missed receive frame, bus-grant timeout, receive done and transmit done. Each pulse sets a sticky flag. The host reads the flags and clears any of them by writing a one to its bit.

A separate mask register holds one mask bit for each event that can interrupt. A global enable input gates the combined interrupt. A read-only summary error bit shows whether any of the four error flags is set, whatever the masks and the enable are. The collision-check flag never interrupts. Hard reset, soft reset and a stop strobe each clear every flag. A 16-bit saturating counter counts missed-frame pulses. Either reset clears the counter. The stop strobe does not.

All resets are synchronous and active high. The interrupt output comes from a register, so it follows the flag state with one cycle of delay.

Top module: `nic_irq_status`

## Requirements
- R1: An event pulse sets its flag in the status word one cycle later. The status bit positions are: babble 14, collision-check 13, missed frame 12, bus timeout 11, receive done 10, transmit done 9. All other bits below 15 read zero. Receive done is set by `ev_rx_last`. It is also set by `ev_rx_first`, but only while `lookahead_en` is 1.
- R2: A write to the status word with `stat_wr` clears each flag whose `wdata` bit is one. Flags whose `wdata` bit is zero keep their value.
- R3: If an event pulse and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R4: `rst`, `soft_rst` and `stop` each clear all six flags on the next edge. This clearing wins over an event pulse in the same cycle.
- R5: Status bit 15 is read-only. It is 1 exactly when at least one of babble, collision-check, missed frame or bus timeout is set. The mask bits and `irq_en` have no effect on it.
- R6: `irq_n` is driven low one cycle after a cycle in which `irq_en` is 1 and at least one of babble, missed frame, bus timeout, receive done or transmit done is set while its mask bit is 0. The mask bits sit at positions 14, 12, 11, 10 and 9 of the mask word.
- R7: The collision-check flag never drives `irq_n` low.
- R8: `irq_n` returns high one cycle after the last enabled, unmasked flag is cleared or masked, or after `irq_en` drops. Both resets force it high.
- R9: `miss_cnt` adds one for each `ev_miss` pulse and holds at 0xFFFF once it gets there. Either reset clears it. `stop` leaves it unchanged.
- R10: The mask word is written with `mask_wr`. Only bits 14, 12, 11, 10 and 9 can be written. Every other bit reads zero. Both resets clear the mask word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Stop strobe; clears all flags |
| irq_en | input | 1 | Global interrupt enable |
| lookahead_en | input | 1 | Lets a first-descriptor handback set receive done |
| ev_babble | input | 1 | Babble event pulse |
| ev_coll_err | input | 1 | Collision-check error pulse |
| ev_miss | input | 1 | Missed-frame pulse |
| ev_bus_to | input | 1 | Bus-grant timeout pulse |
| ev_rx_last | input | 1 | Last receive descriptor handed back |
| ev_rx_first | input | 1 | First receive descriptor handed back |
| ev_tx_done | input | 1 | Transmit done pulse |
| stat_wr | input | 1 | Write-one-to-clear strobe for the status word |
| mask_wr | input | 1 | Write strobe for the mask word |
| wdata | input | 16 | Host write data |
| stat_rd | output | 16 | Status word: flags and summary error bit |
| mask_rd | output | 16 | Mask word read-back |
| irq_n | output | 1 | Combined interrupt, active low, registered |
| miss_cnt | output | 16 | Saturating missed-frame count |

## Verification
A flag stuck at one or lost shows up on `stat_rd` on the edge after the pulse or the write that should have changed it. The same fault then shows on `irq_n` one edge later whenever that flag is enabled and unmasked. A wrong mask bit, or a collision flag wired into the interrupt, becomes visible on `irq_n` within two cycles of setting any flag. A counter that wraps or is wrongly cleared differs on `miss_cnt` on the first edge after the fault. The bench keeps a behavioural model that is stepped on every edge and compares all four outputs in every cycle, so a divergence is reported in the cycle it appears.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int NFLAG   = 6;
  localparam int REG_W   = 16;
  localparam int FLAG_HI = 14;
  localparam int ERR_POS = 15;
  localparam int CNT_W   = 16;

  // flag index order: babble, collision-check, missed, bus timeout, rx done, tx done
  localparam int IX_BABL  = 0;
  localparam int IX_COLL  = 1;
  localparam int IX_MISS  = 2;
  localparam int IX_BUSTO = 3;
  localparam int IX_RXDN  = 4;
  localparam int IX_TXDN  = 5;

  // flags feeding the summary error bit
  localparam logic [NFLAG-1:0] ERR_SRC = 6'b001111;
  // flags that may raise the interrupt (collision-check excluded)
  localparam logic [NFLAG-1:0] IRQ_CAP = 6'b111101;
endpackage

// File: rtl/nic_irq_flag_bank.sv
module nic_irq_flag_bank #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr_all)  flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/nic_irq_mask_reg.sv
module nic_irq_mask_reg #(
  parameter int              NF  = 6,
  parameter logic [NF-1:0]   CAP = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [NF-1:0] wbits,
  output logic [NF-1:0] mask
);
  for (genvar i = 0; i < NF; i++) begin : g_mask
    if (CAP[i]) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)     mask[i] <= 1'b0;
        else if (wr) mask[i] <= wbits[i];
      end
    end else begin : g_none
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/nic_irq_combine.sv
module nic_irq_combine #(
  parameter int            NF  = 6,
  parameter logic [NF-1:0] CAP = '1,
  parameter logic [NF-1:0] ERR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [NF-1:0] flags,
  input  logic [NF-1:0] mask,
  output logic          err,
  output logic          irq_n
);
  logic active;

  assign active = en && ((flags & ~mask & CAP) != '0);
  assign err    = (flags & ERR) != '0;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~active;
  end
endmodule

// File: rtl/nic_irq_sat_counter.sv
module nic_irq_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                      count <= '0;
    else if (inc && count != TOP) count <= count + ONE;
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              irq_en,
  input  logic              lookahead_en,
  input  logic              ev_babble,
  input  logic              ev_coll_err,
  input  logic              ev_miss,
  input  logic              ev_bus_to,
  input  logic              ev_rx_last,
  input  logic              ev_rx_first,
  input  logic              ev_tx_done,
  input  logic              stat_wr,
  input  logic              mask_wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  stat_rd,
  output logic [REG_W-1:0]  mask_rd,
  output logic              irq_n,
  output logic [CNT_W-1:0]  miss_cnt
);
  logic [NFLAG-1:0] set_vec, clr_vec, mask_wbits, flags, mask;
  logic             any_rst, err;

  assign any_rst = rst | soft_rst;

  always_comb begin
    set_vec           = '0;
    set_vec[IX_BABL]  = ev_babble;
    set_vec[IX_COLL]  = ev_coll_err;
    set_vec[IX_MISS]  = ev_miss;
    set_vec[IX_BUSTO] = ev_bus_to;
    set_vec[IX_RXDN]  = ev_rx_last | (ev_rx_first & lookahead_en);
    set_vec[IX_TXDN]  = ev_tx_done;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_map
    assign clr_vec[i]    = stat_wr & wdata[FLAG_HI-i];
    assign mask_wbits[i] = wdata[FLAG_HI-i];
  end

  always_comb begin
    stat_rd          = '0;
    mask_rd          = '0;
    for (int i = 0; i < NFLAG; i++) begin
      stat_rd[FLAG_HI-i] = flags[i];
      mask_rd[FLAG_HI-i] = mask[i];
    end
    stat_rd[ERR_POS] = err;
  end

  nic_irq_flag_bank #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst(any_rst), .clr_all(stop),
    .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  nic_irq_mask_reg #(.NF(NFLAG), .CAP(IRQ_CAP)) u_mask (
    .clk(clk), .rst(any_rst), .wr(mask_wr), .wbits(mask_wbits), .mask(mask)
  );

  nic_irq_combine #(.NF(NFLAG), .CAP(IRQ_CAP), .ERR(ERR_SRC)) u_comb (
    .clk(clk), .rst(any_rst), .en(irq_en), .flags(flags), .mask(mask),
    .err(err), .irq_n(irq_n)
  );

  nic_irq_sat_counter #(.W(CNT_W)) u_miss (
    .clk(clk), .rst(any_rst), .inc(ev_miss), .count(miss_cnt)
  );
endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        soft_rst,
  input logic        stop,
  input logic        irq_en,
  input logic        ev_babble,
  input logic        ev_miss,
  input logic        ev_rx_last,
  input logic        ev_rx_first,
  input logic        stat_wr,
  input logic [15:0] wdata,
  input logic [15:0] stat_rd,
  input logic [15:0] mask_rd,
  input logic        irq_n,
  input logic [15:0] miss_cnt
);
  // R1
  babble_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_babble && !stop && !soft_rst) |=> stat_rd[14]);

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata[10] && !ev_rx_last && !ev_rx_first) |=> !stat_rd[10]);

  // R2
  zero_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd[12] && !(stat_wr && wdata[12]) && !stop && !soft_rst) |=> stat_rd[12]);

  // R3
  set_over_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_miss && stat_wr && wdata[12] && !stop && !soft_rst) |=> stat_rd[12]);

  // R4
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stop || soft_rst) |=> (stat_rd[14:9] == 6'b0));

  // R5
  err_summary_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd[15] == (|stat_rd[14:11]));

  // R6
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en && !soft_rst && ((stat_rd[14:9] & ~mask_rd[14:9] & 6'b101111) != 6'b0))
    |=> !irq_n);

  // R7
  coll_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_rd[14:9] & 6'b101111) == 6'b0) |=> irq_n);

  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt == 16'hFFFF && !soft_rst) |=> miss_cnt == 16'hFFFF);
endmodule

bind nic_irq_status nic_irq_status_chk u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop(stop), .irq_en(irq_en),
  .ev_babble(ev_babble), .ev_miss(ev_miss), .ev_rx_last(ev_rx_last),
  .ev_rx_first(ev_rx_first), .stat_wr(stat_wr), .wdata(wdata),
  .stat_rd(stat_rd), .mask_rd(mask_rd), .irq_n(irq_n), .miss_cnt(miss_cnt)
);

// File: tb/nic_irq_status_bench.sv
`timescale 1ns/1ps
module nic_irq_status_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0, stop = 1'b0, irq_en = 1'b0, lookahead_en = 1'b0;
  logic ev_babble = 0, ev_coll_err = 0, ev_miss = 0, ev_bus_to = 0;
  logic ev_rx_last = 0, ev_rx_first = 0, ev_tx_done = 0;
  logic stat_wr = 0, mask_wr = 0;
  logic [15:0] wdata = '0;
  logic [15:0] stat_rd, mask_rd, miss_cnt;
  logic        irq_n;

  int total = 0, bad = 0;
  bit finished = 0, model_live = 0;

  always #4 clk = ~clk;

  nic_irq_status u_nic_irq_status (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop(stop), .irq_en(irq_en),
    .lookahead_en(lookahead_en), .ev_babble(ev_babble), .ev_coll_err(ev_coll_err),
    .ev_miss(ev_miss), .ev_bus_to(ev_bus_to), .ev_rx_last(ev_rx_last),
    .ev_rx_first(ev_rx_first), .ev_tx_done(ev_tx_done), .stat_wr(stat_wr),
    .mask_wr(mask_wr), .wdata(wdata), .stat_rd(stat_rd), .mask_rd(mask_rd),
    .irq_n(irq_n), .miss_cnt(miss_cnt)
  );

  // behavioural reference, bit positions as listed in the requirements
  bit [15:0] m_flags, m_mask;
  bit        m_irq_n;
  int        m_cnt;

  function automatic bit [15:0] m_status();
    bit [15:0] s = m_flags;
    s[15] = (m_flags[14] | m_flags[13] | m_flags[12] | m_flags[11]);
    return s;
  endfunction

  always @(posedge clk) begin
    bit [15:0] nf;
    if (rst || soft_rst) begin
      m_flags = 0; m_mask = 0; m_cnt = 0; m_irq_n = 1;
    end else begin
      m_irq_n = !(irq_en && ((m_flags & ~m_mask & 16'h5E00) != 0));
      if (ev_miss && m_cnt < 65535) m_cnt++;
      if (stop) nf = 0;
      else begin
        nf = m_flags;
        if (stat_wr) nf = nf & ~wdata;
        if (ev_babble)   nf[14] = 1;
        if (ev_coll_err) nf[13] = 1;
        if (ev_miss)     nf[12] = 1;
        if (ev_bus_to)   nf[11] = 1;
        if (ev_rx_last || (ev_rx_first && lookahead_en)) nf[10] = 1;
        if (ev_tx_done)  nf[9] = 1;
      end
      if (mask_wr) m_mask = wdata & 16'h5E00;
      m_flags = nf;
    end
    model_live = 1;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_live && !finished) begin
    chk("model stat_rd", int'(stat_rd), int'(m_status()));
    chk("model mask_rd", int'(mask_rd), int'(m_mask));
    chk("model irq_n", int'(irq_n), int'(m_irq_n));
    chk("model miss_cnt", int'(miss_cnt), m_cnt);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    {ev_babble, ev_coll_err, ev_miss, ev_bus_to, ev_rx_last, ev_rx_first, ev_tx_done} = '0;
    {stat_wr, mask_wr, stop, soft_rst, rst} = '0;
    wdata = '0;
  endtask

  task automatic w1c(logic [15:0] v); stat_wr = 1; wdata = v; tick(); idle(); endtask
  task automatic wmask(logic [15:0] v); mask_wr = 1; wdata = v; tick(); idle(); endtask

  initial begin
    #(8 * 190000);
    chk("watchdog expired", 1, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; repeat (3) tick(); idle(); 
    // reset state
    chk("R10 reset mask", int'(mask_rd), 0);
    chk("R4 reset status", int'(stat_rd), 0);
    chk("R8 reset irq_n", int'(irq_n), 1);
    chk("R9 reset count", int'(miss_cnt), 0);

    wmask(16'hFFFF);
    chk("R10 writable mask bits", int'(mask_rd), 16'h5E00);
    wmask(16'h0000);

    irq_en = 0;
    ev_babble = 1; tick(); idle();
    chk("R1 babble at bit 14, R5 error bit", int'(stat_rd), 16'hC000);
    tick();
    chk("R5 no irq while disabled", int'(irq_n), 1);
    w1c(16'h0000);
    chk("R2 zero write keeps flag", int'(stat_rd), 16'hC000);
    w1c(16'h4000);
    chk("R2 one write clears flag", int'(stat_rd), 16'h0000);

    ev_rx_first = 1; tick(); idle();
    chk("R1 rx_first ignored without lookahead", int'(stat_rd), 0);
    lookahead_en = 1; ev_rx_first = 1; tick(); idle(); lookahead_en = 0;
    chk("R1 rx_first with lookahead", int'(stat_rd), 16'h0400);
    w1c(16'h0400);

    irq_en = 1;
    ev_tx_done = 1; tick(); idle();
    chk("R1 tx done bit 9", int'(stat_rd), 16'h0200);
    chk("R6 irq_n registered delay", int'(irq_n), 1);
    tick();
    chk("R6 irq_n low", int'(irq_n), 0);
    wmask(16'h0200);
    chk("R8 irq_n still low same edge as mask", int'(irq_n), 0);
    tick();
    chk("R8 irq_n high after mask", int'(irq_n), 1);
    wmask(16'h0000); tick();
    chk("R6 unmasked again", int'(irq_n), 0);
    w1c(16'h0200);
    chk("R8 flag cleared, irq still low", int'(irq_n), 0);
    tick();
    chk("R8 irq_n high after clear", int'(irq_n), 1);

    ev_coll_err = 1; tick(); idle();
    chk("R5 coll sets error bit", int'(stat_rd), 16'hA000);
    repeat (2) tick();
    chk("R7 coll never interrupts", int'(irq_n), 1);
    ev_coll_err = 1; stat_wr = 1; wdata = 16'h2000; tick(); idle();
    chk("R3 set wins over clear", int'(stat_rd), 16'hA000);

    ev_bus_to = 1; ev_miss = 1; tick(); idle();
    chk("R9 count after miss", int'(miss_cnt), 1);
    tick();
    chk("R6 bus timeout interrupts", int'(irq_n), 0);
    stop = 1; ev_babble = 1; tick(); idle();
    chk("R4 stop clears and beats event", int'(stat_rd), 0);
    chk("R9 stop keeps count", int'(miss_cnt), 1);
    tick();
    chk("R8 irq_n high after stop", int'(irq_n), 1);

    wmask(16'h4000);
    ev_rx_last = 1; tick(); idle();
    soft_rst = 1; tick(); idle();
    chk("R4 soft reset clears flags", int'(stat_rd), 0);
    chk("R10 soft reset clears mask", int'(mask_rd), 0);
    ev_babble = 1; tick(); idle();
    rst = 1; tick(); idle();
    chk("R4 hard reset clears flags", int'(stat_rd), 0);

    ev_miss = 1; repeat (65540) tick(); idle();
    chk("R9 count saturates", int'(miss_cnt), 16'hFFFF);
    soft_rst = 1; tick(); idle();
    chk("R9 soft reset clears count", int'(miss_cnt), 0);

    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 64);
      irq_en = $urandom % 4 != 0;
      lookahead_en = $urandom % 2 == 1;
      ev_babble = r < 6; ev_coll_err = r % 11 == 0; ev_miss = r % 7 == 0;
      ev_bus_to = r % 13 == 0; ev_rx_last = r % 5 == 0; ev_rx_first = r % 9 == 0;
      ev_tx_done = r % 6 == 0;
      stat_wr = $urandom % 4 == 0; mask_wr = $urandom % 8 == 0;
      wdata = 16'($urandom);
      stop = $urandom % 97 == 0; soft_rst = $urandom % 211 == 0;
      tick();
    end
    idle(); tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule